// File: doc/BRIEF.md
# Programmable Tag Check Unit

This unit sits beside an instruction pipeline and judges each instruction that runs outside trusted mode. Every register and memory word carries one tag bit per security policy, and four policies are active at once. For each policy a configuration register says which operands of which operation classes must be clean. If an enabled operand arrives with that policy's tag bit set, the unit requests a security exception. It also reports which policies failed and which operand was the cause.

The pipeline presents a decoded class vector, a custom-operation match and the tags of seven operands. These are the program counter, the fetched instruction word, the source and destination addresses of a move, and the two sources and the destination of the datapath operation. The result is registered and appears one cycle later. Configuration is written through a small port, and the write is accepted only while the pipeline is in trusted mode. Sequencing of the exception itself is left to the pipeline.

The output stage is a two-state machine. ST_CLEAR means no request is pending. ST_RAISED means the instruction of the previous cycle failed a check. The transition to ST_RAISED (raise) is taken on every edge at which an untrusted valid instruction fails at least one enabled check. The transition to ST_CLEAR (clear) is taken on every other edge, so a request lasts exactly one cycle for each failing instruction.

Top module: `tag_check_unit`

## Requirements
- R1: After reset, every configuration register is zero and all outputs are zero, so no instruction raises a request until a configuration is written.
- R2: The execute checks apply to every checked instruction, whatever its class. Configuration bit 0 checks the program counter tag and bit 1 checks the fetched instruction tag.
- R3: For the move class (class vector bit 3), bit 2 checks the source-1 tag, bit 3 the source address tag, bit 4 the destination address tag and bit 5 the destination tag.
- R4: The arithmetic, logic and compare classes (class vector bits 0, 1, 2) each have a source enable (bits 6, 8, 10) and a destination enable (bits 7, 9, 11). A source enable checks both source tags.
- R5: When the custom match is set, slot k's enables at bits 12+3k, 13+3k and 14+3k check source 1, source 2 and the destination. These replace all class operand enables, including the move address checks. The execute checks still apply.
- R6: While trusted mode is set, an instruction raises no request, whatever its tags and the configuration.
- R7: A configuration write (the select picks the policy) takes effect only when trusted mode is set in the same cycle. An untrusted write leaves the register unchanged.
- R8: The failing-policy mask has bit p set when policy p failed any enabled check. Several bits may be set in the same cycle. The request is high exactly when the mask is non-zero.
- R9: The operand code reports the highest-priority failing operand over all policies: 1 program counter, 2 instruction, 3 source address, 4 destination address, 5 source 1, 6 source 2, 7 destination. It is 0 when nothing fails.
- R10: The outputs for an instruction presented in cycle N appear after the clock edge that ends cycle N. A configuration written in cycle N governs instructions from cycle N+1.
- R11: With the valid input low, the next cycle shows no request, a zero mask and a zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trusted | input | 1 | Pipeline runs in trusted mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Policy whose register is written |
| cfg_wdata | input | 18 | Configuration value |
| chk_valid | input | 1 | An instruction is presented this cycle |
| class_vec | input | 4 | Decoded class: arith, logic, compare, move |
| cust_hit | input | 1 | A custom slot matched |
| cust_idx | input | 1 | Index of the matching custom slot |
| tag_pc | input | 4 | Program counter tag, one bit per policy |
| tag_insn | input | 4 | Fetched instruction tag |
| tag_saddr | input | 4 | Source address tag |
| tag_daddr | input | 4 | Destination address tag |
| tag_rs1 | input | 4 | Source 1 tag |
| tag_rs2 | input | 4 | Source 2 tag |
| tag_rd | input | 4 | Destination tag |
| exc_req | output | 1 | Security exception request |
| fail_mask | output | 4 | Policies that failed |
| fail_opnd | output | 3 | Code of the highest-priority failing operand |

## Verification
Two functions of this block can fall in the same cycle. The first is failures from several policies, which merge into the mask. The second is failures on several operands, which must collapse to one code by priority. The bench provokes both with instructions whose tags set several operand bits across several policies, once in directed cases and then in a long run of random tags and configurations. On every clock, a behavioural reference model predicts the full mask and the single winning operand code. Both must match the registered outputs, and they are judged together so that a correct mask cannot hide a wrong winner.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    // configuration field positions (per policy register)
    localparam int EN_PC      = 0;
    localparam int EN_INSN    = 1;
    localparam int EN_MV_SRC  = 2;
    localparam int EN_MV_SADR = 3;
    localparam int EN_MV_DADR = 4;
    localparam int EN_MV_DST  = 5;
    localparam int EN_AR_SRC  = 6;
    localparam int EN_AR_DST  = 7;
    localparam int EN_LG_SRC  = 8;
    localparam int EN_LG_DST  = 9;
    localparam int EN_CP_SRC  = 10;
    localparam int EN_CP_DST  = 11;
    localparam int CUST_BASE  = 12;
    localparam int CUST_FLDS  = 3;

    // class vector positions
    localparam int CL_ARITH = 0;
    localparam int CL_LOGIC = 1;
    localparam int CL_CMP   = 2;
    localparam int CL_MOVE  = 3;
    localparam int NUM_CLASS = 4;

    // operand slots in priority order (index 0 wins)
    localparam int NUM_OPND = 7;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PC    = 3'd1,
        OP_INSN  = 3'd2,
        OP_SADDR = 3'd3,
        OP_DADDR = 3'd4,
        OP_RS1   = 3'd5,
        OP_RS2   = 3'd6,
        OP_RD    = 3'd7
    } opnd_e;

    typedef enum logic {
        ST_CLEAR  = 1'b0,
        ST_RAISED = 1'b1
    } out_state_e;

endpackage

// File: rtl/tcu_cfg_bank.sv
module tcu_cfg_bank #(
    parameter int NUM_POL = 4,
    parameter int CFG_W   = 18,
    parameter int SEL_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            trusted,
    input  logic                            we,
    input  logic [SEL_W-1:0]                sel,
    input  logic [CFG_W-1:0]                wdata,
    output logic [NUM_POL-1:0][CFG_W-1:0]   cfg
);

    for (genvar p = 0; p < NUM_POL; p++) begin : g_reg
        logic hit;
        assign hit = we && trusted && (sel == SEL_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[p] <= '0;
            end else if (hit) begin
                cfg[p] <= wdata;
            end
        end
    end

endmodule

// File: rtl/tcu_policy_eval.sv
module tcu_policy_eval
    import tcu_pkg::*;
#(
    parameter int CFG_W    = 18,
    parameter int NUM_CUST = 2,
    parameter int CI_W     = 1
) (
    input  logic [CFG_W-1:0]     cfg,
    input  logic [NUM_CLASS-1:0] cls,
    input  logic                 cust_hit,
    input  logic [CI_W-1:0]      cust_idx,
    input  logic                 t_pc,
    input  logic                 t_insn,
    input  logic                 t_saddr,
    input  logic                 t_daddr,
    input  logic                 t_rs1,
    input  logic                 t_rs2,
    input  logic                 t_rd,
    output logic [NUM_OPND-1:0]  fail
);

    logic [CUST_FLDS-1:0] cust_en;
    logic src_cls, dst_cls;
    logic en_rs1, en_rs2, en_rd, en_sa, en_da;

    // custom slot enables, selected by index
    if (NUM_CUST == 1) begin : g_one_slot
        assign cust_en = cfg[CUST_BASE +: CUST_FLDS];
    end else begin : g_many_slots
        logic [NUM_CUST-1:0][CUST_FLDS-1:0] slot;
        for (genvar k = 0; k < NUM_CUST; k++) begin : g_slot
            assign slot[k] = cfg[CUST_BASE + CUST_FLDS*k +: CUST_FLDS];
        end
        always_comb begin
            cust_en = '0;
            for (int k = 0; k < NUM_CUST; k++) begin
                if (cust_idx == CI_W'(k)) cust_en = slot[k];
            end
        end
    end

    always_comb begin
        src_cls = (cls[CL_ARITH] & cfg[EN_AR_SRC])
                | (cls[CL_LOGIC] & cfg[EN_LG_SRC])
                | (cls[CL_CMP]   & cfg[EN_CP_SRC]);
        dst_cls = (cls[CL_ARITH] & cfg[EN_AR_DST])
                | (cls[CL_LOGIC] & cfg[EN_LG_DST])
                | (cls[CL_CMP]   & cfg[EN_CP_DST])
                | (cls[CL_MOVE]  & cfg[EN_MV_DST]);
        if (cust_hit) begin
            en_rs1 = cust_en[0];
            en_rs2 = cust_en[1];
            en_rd  = cust_en[2];
            en_sa  = 1'b0;
            en_da  = 1'b0;
        end else begin
            en_rs1 = src_cls | (cls[CL_MOVE] & cfg[EN_MV_SRC]);
            en_rs2 = src_cls;
            en_rd  = dst_cls;
            en_sa  = cls[CL_MOVE] & cfg[EN_MV_SADR];
            en_da  = cls[CL_MOVE] & cfg[EN_MV_DADR];
        end
        fail[0] = cfg[EN_PC]   & t_pc;
        fail[1] = cfg[EN_INSN] & t_insn;
        fail[2] = en_sa  & t_saddr;
        fail[3] = en_da  & t_daddr;
        fail[4] = en_rs1 & t_rs1;
        fail[5] = en_rs2 & t_rs2;
        fail[6] = en_rd  & t_rd;
    end

endmodule

// File: rtl/tcu_prio_enc.sv
module tcu_prio_enc
    import tcu_pkg::*;
(
    input  logic [NUM_OPND-1:0] req,
    output opnd_e               code
);

    always_comb begin
        code = OP_NONE;
        for (int i = NUM_OPND - 1; i >= 0; i--) begin
            if (req[i]) code = opnd_e'(i + 1);
        end
    end

endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
    import tcu_pkg::*;
#(
    parameter int NUM_POL  = 4,
    parameter int NUM_CUST = 2,
    localparam int CFG_W   = CUST_BASE + CUST_FLDS*NUM_CUST,
    localparam int SEL_W   = (NUM_POL > 1) ? $clog2(NUM_POL) : 1,
    localparam int CI_W    = (NUM_CUST > 1) ? $clog2(NUM_CUST) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trusted,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 chk_valid,
    input  logic [NUM_CLASS-1:0] class_vec,
    input  logic                 cust_hit,
    input  logic [CI_W-1:0]      cust_idx,
    input  logic [NUM_POL-1:0]   tag_pc,
    input  logic [NUM_POL-1:0]   tag_insn,
    input  logic [NUM_POL-1:0]   tag_saddr,
    input  logic [NUM_POL-1:0]   tag_daddr,
    input  logic [NUM_POL-1:0]   tag_rs1,
    input  logic [NUM_POL-1:0]   tag_rs2,
    input  logic [NUM_POL-1:0]   tag_rd,
    output logic                 exc_req,
    output logic [NUM_POL-1:0]   fail_mask,
    output logic [2:0]           fail_opnd
);

    logic [NUM_POL-1:0][CFG_W-1:0]    cfg;
    logic [NUM_POL-1:0][NUM_OPND-1:0] pol_fail;
    logic [NUM_POL-1:0]               mask_d;
    logic [NUM_OPND-1:0]              opnd_any;
    opnd_e                            code_d;
    logic                             active;
    out_state_e                       state_q, state_d;
    logic [NUM_POL-1:0]               mask_q;
    opnd_e                            code_q;

    tcu_cfg_bank #(.NUM_POL(NUM_POL), .CFG_W(CFG_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .trusted(trusted), .we(cfg_we),
        .sel(cfg_sel), .wdata(cfg_wdata), .cfg(cfg)
    );

    for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
        tcu_policy_eval #(.CFG_W(CFG_W), .NUM_CUST(NUM_CUST), .CI_W(CI_W)) u_eval (
            .cfg(cfg[p]), .cls(class_vec), .cust_hit(cust_hit), .cust_idx(cust_idx),
            .t_pc(tag_pc[p]), .t_insn(tag_insn[p]), .t_saddr(tag_saddr[p]),
            .t_daddr(tag_daddr[p]), .t_rs1(tag_rs1[p]), .t_rs2(tag_rs2[p]),
            .t_rd(tag_rd[p]), .fail(pol_fail[p])
        );
        assign mask_d[p] = |pol_fail[p];
    end

    always_comb begin
        opnd_any = '0;
        for (int p = 0; p < NUM_POL; p++) opnd_any |= pol_fail[p];
    end

    tcu_prio_enc u_prio (.req(opnd_any), .code(code_d));

    assign active = chk_valid && !trusted;

    // next-state logic
    always_comb begin
        state_d = ST_CLEAR;
        unique case (state_q)
            ST_CLEAR:  if (active && (mask_d != '0)) state_d = ST_RAISED;
            ST_RAISED: if (active && (mask_d != '0)) state_d = ST_RAISED;
            default:   state_d = ST_CLEAR;
        endcase
    end

    // state and report registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            mask_q  <= '0;
            code_q  <= OP_NONE;
        end else begin
            state_q <= state_d;
            mask_q  <= active ? mask_d : '0;
            code_q  <= active ? code_d : OP_NONE;
        end
    end

    // outputs
    always_comb begin
        exc_req   = 1'b0;
        fail_mask = '0;
        fail_opnd = OP_NONE;
        unique case (state_q)
            ST_CLEAR:  ;
            ST_RAISED: begin
                exc_req   = 1'b1;
                fail_mask = mask_q;
                fail_opnd = code_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
    parameter int NUM_POL = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trusted,
    input logic               chk_valid,
    input logic               exc_req,
    input logic [NUM_POL-1:0] fail_mask,
    input logic [2:0]         fail_opnd
);

    p_trusted_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && trusted) |=> (!exc_req && fail_mask == '0));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!exc_req && fail_opnd == 3'd0));

    p_mask_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (fail_mask != '0));

    p_code_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req == (fail_opnd != 3'd0)));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !$past(chk_valid)) |-> 1'b0);

endmodule

bind tag_check_unit tcu_checker #(.NUM_POL(NUM_POL)) u_tcu_chk (
    .clk(clk), .rst_n(rst_n), .trusted(trusted), .chk_valid(chk_valid),
    .exc_req(exc_req), .fail_mask(fail_mask), .fail_opnd(fail_opnd)
);

// File: tb/tag_check_unit_tb_top.sv
module tag_check_unit_tb_top;

    localparam int NP = 4;
    localparam int CW = 18;

    logic clk = 1'b0;
    logic rst_n;
    logic trusted, cfg_we, chk_valid, cust_hit;
    logic [1:0] cfg_sel;
    logic [CW-1:0] cfg_wdata;
    logic [3:0] class_vec;
    logic [0:0] cust_idx;
    logic [NP-1:0] tag_pc, tag_insn, tag_saddr, tag_daddr, tag_rs1, tag_rs2, tag_rd;
    logic exc_req;
    logic [NP-1:0] fail_mask;
    logic [2:0] fail_opnd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_req = "R1";
    logic [CW-1:0] mcfg [NP];

    always #5 clk = ~clk;

    tag_check_unit dut_i (
        .clk(clk), .rst_n(rst_n), .trusted(trusted), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .chk_valid(chk_valid),
        .class_vec(class_vec), .cust_hit(cust_hit), .cust_idx(cust_idx),
        .tag_pc(tag_pc), .tag_insn(tag_insn), .tag_saddr(tag_saddr),
        .tag_daddr(tag_daddr), .tag_rs1(tag_rs1), .tag_rs2(tag_rs2), .tag_rd(tag_rd),
        .exc_req(exc_req), .fail_mask(fail_mask), .fail_opnd(fail_opnd)
    );

    // behavioural enable of operand o (0 pc .. 6 rd) for a config word
    function automatic bit op_en(input logic [CW-1:0] c, input int o,
                                 input logic [3:0] cl, input bit ch, input int ci);
        bit r = 0;
        case (o)
            0: r = c[0];
            1: r = c[1];
            2: r = !ch && cl[3] && c[3];
            3: r = !ch && cl[3] && c[4];
            4: r = ch ? c[12+3*ci] : ((cl[3] && c[2]) || (cl[0] && c[6]) || (cl[1] && c[8]) || (cl[2] && c[10]));
            5: r = ch ? c[13+3*ci] : ((cl[0] && c[6]) || (cl[1] && c[8]) || (cl[2] && c[10]));
            6: r = ch ? c[14+3*ci] : ((cl[3] && c[5]) || (cl[0] && c[7]) || (cl[1] && c[9]) || (cl[2] && c[11]));
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic check(input logic ee, input logic [3:0] em, input logic [2:0] eo);
        n_tests++;
        if (exc_req !== ee || fail_mask !== em || fail_opnd !== eo) begin
            n_fail++;
            $display("FAIL %s: actual req=%0b mask=%b opnd=%0d expected req=%0b mask=%b opnd=%0d",
                     cur_req, exc_req, fail_mask, fail_opnd, ee, em, eo);
        end
    endtask

    // one clock: drive at negedge, compare at following negedge
    task automatic step(input bit tr, input bit we, input int sel, input logic [CW-1:0] wd,
                        input bit vld, input logic [3:0] cl, input bit ch, input int ci,
                        input logic [6:0][3:0] t);
        logic [3:0] em;
        int eo;
        trusted = tr; cfg_we = we; cfg_sel = sel[1:0]; cfg_wdata = wd;
        chk_valid = vld; class_vec = cl; cust_hit = ch; cust_idx = ci[0:0];
        tag_pc = t[0]; tag_insn = t[1]; tag_saddr = t[2]; tag_daddr = t[3];
        tag_rs1 = t[4]; tag_rs2 = t[5]; tag_rd = t[6];
        em = '0; eo = 0;
        if (vld && !tr) begin
            for (int o = 6; o >= 0; o--) begin
                bit hit = 0;
                for (int p = 0; p < NP; p++) begin
                    if (op_en(mcfg[p], o, cl, ch, ci) && t[o][p]) begin
                        em[p] = 1'b1;
                        hit = 1;
                    end
                end
                if (hit) eo = o + 1;
            end
        end
        if (we && tr) mcfg[sel] = wd;
        @(negedge clk);
        check(em != 0, em, eo[2:0]);
    endtask

    task automatic wr(input int sel, input logic [CW-1:0] wd);
        step(1, 1, sel, wd, 0, 0, 0, 0, '0);
    endtask

    task automatic ins(input logic [3:0] cl, input bit ch, input int ci,
                       input logic [6:0][3:0] t);
        step(0, 0, 0, '0, 1, cl, ch, ci, t);
    endtask

    function automatic logic [6:0][3:0] one_tag(input int o, input logic [3:0] pols);
        logic [6:0][3:0] t = '0;
        t[o] = pols;
        return t;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10: watchdog expired, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [6:0][3:0] all1;
        for (int i = 0; i < 7; i++) all1[i] = 4'hF;
        for (int p = 0; p < NP; p++) mcfg[p] = '0;
        rst_n = 0; trusted = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        chk_valid = 0; class_vec = 0; cust_hit = 0; cust_idx = 0;
        tag_pc = 0; tag_insn = 0; tag_saddr = 0; tag_daddr = 0;
        tag_rs1 = 0; tag_rs2 = 0; tag_rd = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1"; check(0, 4'h0, 3'd0);
        rst_n = 1;
        ins(4'hF, 0, 0, all1);                      // R1: zero config, no request

        cur_req = "R2";
        wr(0, 18'h1);                               // R10: visible next cycle
        ins(4'h0, 0, 0, one_tag(0, 4'h1));
        wr(0, 18'h2);
        ins(4'h1, 0, 0, one_tag(1, 4'h1));
        ins(4'h1, 0, 0, one_tag(0, 4'h1));          // pc check now off

        cur_req = "R7";
        step(0, 1, 1, 18'h3FFFF, 0, 0, 0, 0, '0);   // untrusted write ignored
        ins(4'hF, 0, 0, all1);

        cur_req = "R3";
        wr(1, 18'h3C);
        for (int o = 2; o <= 6; o++) ins(4'h8, 0, 0, one_tag(o, 4'h2));
        ins(4'h1, 0, 0, one_tag(2, 4'h2));          // address check needs move class

        cur_req = "R4";
        wr(2, 18'h0A40);                            // arith src, logic dst, cmp dst
        ins(4'h1, 0, 0, one_tag(5, 4'h4));
        ins(4'h1, 0, 0, one_tag(6, 4'h4));
        ins(4'h2, 0, 0, one_tag(6, 4'h4));
        ins(4'h4, 0, 0, one_tag(4, 4'h4));
        ins(4'h4, 0, 0, one_tag(6, 4'h4));

        cur_req = "R5";
        wr(3, 18'b100_011_000011000000);            // slot0 rs1+rs2, slot1 rd, arith src/dst
        ins(4'h1, 1, 0, one_tag(6, 4'h8));          // custom replaces arith dst
        ins(4'h1, 1, 0, one_tag(5, 4'h8));
        ins(4'h1, 1, 1, one_tag(6, 4'h8));
        ins(4'h1, 1, 1, one_tag(4, 4'h8));
        ins(4'h8, 1, 0, one_tag(3, 4'h2));          // move address off under custom

        cur_req = "R6";
        step(1, 0, 0, '0, 1, 4'hF, 0, 0, all1);

        cur_req = "R11";
        step(0, 0, 0, '0, 0, 4'hF, 0, 0, all1);

        cur_req = "R8";
        wr(0, 18'h3FFFF); wr(1, 18'h3FFFF); wr(2, 18'h3FFFF); wr(3, 18'h3FFFF);
        ins(4'h1, 0, 0, one_tag(4, 4'hB));

        cur_req = "R9";
        for (int o = 6; o >= 0; o--) begin
            logic [6:0][3:0] t = '0;
            for (int k = o; k < 7; k++) t[k] = 4'(1 << (k % 4));
            ins(4'h8, 0, 0, t);
        end

        cur_req = "R9";                             // random mix, shared cycle mask+priority
        for (int i = 0; i < 3000; i++) begin
            logic [6:0][3:0] t;
            for (int k = 0; k < 7; k++) t[k] = 4'($urandom & ($urandom | $urandom));
            if ($urandom % 5 == 0)
                step($urandom % 2, 1, $urandom % 4, 18'($urandom), 0, 0, 0, 0, '0);
            else
                step($urandom % 8 == 0, 0, 0, '0, $urandom % 6 != 0, 4'(1 << ($urandom % 4)),
                     $urandom % 3 == 0, $urandom % 2, t);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule